// File: doc/BRIEF.md
# Periodic Wake Timer with Watchdog and Supply Supervision

This block is a long-interval timer for a system that sleeps most of the time. While the power-ok input is high it counts a selectable number of base oscillator periods. Each time the count runs out it sends one of two pulses to the host processor. A wake pulse is the normal outcome. An active-low reset pulse is the penalty outcome. Either pulse is followed by a calibration pulse that lasts exactly one base period, so the host can measure the oscillator against its own crystal.

The choice of pulse acts as a watchdog. The host must acknowledge each interval with a rising edge on the acknowledge input. If a period elapses without a valid acknowledge, the next expiry issues a reset instead of a wake. The first expiry after power-ok rises is always a reset. As a result, a supply drop that happens while the host sleeps always ends in a reset of the host.

Time is kept with a tick enable that runs at twice the base oscillator rate, so one tick is half a base period. Dropping power-ok clears the whole block at once and forces the outputs to their idle levels.

Top module: `wake_wdog_timer`

## Requirements
- R1: The interval between expiries is N base periods (2N ticks), where N = 2^BASE_LOG2 times 1, 2, 4, 8, 10, 16, 32 or 64 for delay codes 0 to 7 in that order. The default BASE_LOG2 = 6 gives 64 to 4096. The first expiry falls on tick 2N after power-ok rises, counting the first tick as tick 1.
- R2: While pwr_ok is low, wake_pulse and cal_pulse are low and mcu_rst_n is high, without waiting for a clock edge, and nothing counts. A rising pwr_ok restarts the interval count from zero and clears the watchdog state.
- R3: The delay code is captured on the first tick after pwr_ok rises. Later changes to delay_code have no effect until the next power-up.
- R4: The first expiry after power-up always produces a reset pulse. mcu_rst_n goes low after the expiry tick and stays low for 2 ticks.
- R5: At any later expiry, a wake pulse is issued if a valid acknowledge was recorded during the interval that just ended. Otherwise a 2-tick reset pulse is issued.
- R6: wake_pulse goes high after the expiry tick and stays high for 4 ticks (2 base periods).
- R7: cal_pulse goes high one tick after the wake or reset pulse starts and stays high for 2 ticks (1 base period).
- R8: ack_in passes through a two-stage tick-clocked synchronizer. Only a low-to-high change is a valid acknowledge, and it takes effect on the third tick after the input rises. A second valid edge in the same interval is ignored. An edge seen on the expiry tick itself counts toward the new interval.
- R9: A valid acknowledge never restarts or shifts the interval count.
- R10: A valid acknowledge that takes effect while wake_pulse or cal_pulse is high forces both low for the rest of that pulse.
- R11: The synchronous reset rst puts the block in the same state as pwr_ok low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base enable, twice the base oscillator rate |
| pwr_ok | input | 1 | Power-good level, low clears the block asynchronously |
| ack_in | input | 1 | Host acknowledge, asynchronous |
| delay_code | input | 3 | Interval select, captured at power-up |
| wake_pulse | output | 1 | Wake pulse to the host, active high |
| mcu_rst_n | output | 1 | Reset pulse to the host, active low |
| cal_pulse | output | 1 | Calibration pulse, one base period wide |

## Verification
The assertions assume four things about the inputs. The tick runs steadily. pwr_ok changes away from clock edges. ack_in holds each level for at least three ticks. The configured interval is longer than the 4-tick pulse sequence, so pulses never overlap. The stimulus meets these by driving a tick on every clock, changing inputs a quarter period after each edge, and building the design with BASE_LOG2 = 3 so the shortest interval is 16 ticks. Acknowledge edges are placed well clear of the expiry tick, except for the one deliberately placed just after an expiry to exercise R10.

// File: rtl/wkt_pkg.sv
package wkt_pkg;

    localparam int CODE_W     = 3;
    // pulse sequence lengths in ticks (one tick = half base period)
    localparam int WAKE_TICKS = 4;
    localparam int RST_TICKS  = 2;
    localparam int CAL_START  = 1;
    localparam int CAL_TICKS  = 2;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int SEQ_TICKS = imax(WAKE_TICKS, imax(RST_TICKS, CAL_START + CAL_TICKS));
    localparam int PH_W      = (SEQ_TICKS > 1) ? $clog2(SEQ_TICKS) : 1;

    typedef enum logic {
        PK_RESET = 1'b0,
        PK_WAKE  = 1'b1
    } pulse_kind_e;

    typedef struct packed {
        logic              active;
        logic              killed;
        pulse_kind_e       kind;
        logic [PH_W-1:0]   ph;
    } seq_state_t;

    // ticks in one interval: 2 * base * multiplier, multiplier 1,2,4,8,10,16,32,64
    function automatic int unsigned interval_ticks(input logic [CODE_W-1:0] code,
                                                   input int base_log2);
        int unsigned base2;
        base2 = 32'd2 << base_log2;
        if (code == 3'd4)
            return base2 * 10;
        else if (code < 3'd4)
            return base2 << code;
        else
            return base2 << (code - 3'd1);
    endfunction

    function automatic int cnt_width(input int base_log2);
        return base_log2 + 7;
    endfunction

endpackage

// File: rtl/wkt_ack_sync.sv
module wkt_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic ack_in,
    output logic ack_rise
);
    // chain[0..STAGES-1] synchronize, chain[STAGES] holds previous value
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst)
            chain_q <= '0;
        else if (tick)
            chain_q <= {chain_q[STAGES-1:0], ack_in};
    end

    assign ack_rise = chain_q[STAGES-1] & ~chain_q[STAGES];

    // R8
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && ack_rise) |=> !ack_rise);

endmodule

// File: rtl/wkt_delay_counter.sv
module wkt_delay_counter
    import wkt_pkg::*;
#(
    parameter int BASE_LOG2 = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_ok,
    input  logic              tick,
    input  logic [CODE_W-1:0] code,
    output logic              expire
);
    localparam int CNT_W = cnt_width(BASE_LOG2);

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  last_cnt;
    logic              started_q;
    logic [CODE_W-1:0] code_q;

    always_comb last_cnt = CNT_W'(interval_ticks(code_q, BASE_LOG2) - 1);

    always_ff @(posedge clk or negedge pwr_ok) begin
        if (!pwr_ok) begin
            cnt_q     <= '0;
            started_q <= 1'b0;
            code_q    <= '0;
        end else if (rst) begin
            cnt_q     <= '0;
            started_q <= 1'b0;
            code_q    <= '0;
        end else if (tick) begin
            if (!started_q) begin
                started_q <= 1'b1;
                code_q    <= code;
                cnt_q     <= CNT_W'(1);
            end else if (cnt_q == last_cnt) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign expire = tick & started_q & (cnt_q == last_cnt);

    // R1
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst || !pwr_ok)
        started_q |-> (cnt_q <= last_cnt));

    // R3
    code_hold_chk: assert property (@(posedge clk) disable iff (rst || !pwr_ok)
        (started_q && $past(started_q)) |-> $stable(code_q));

endmodule

// File: rtl/wkt_watchdog.sv
module wkt_watchdog (
    input  logic clk,
    input  logic rst,
    input  logic pwr_ok,
    input  logic tick,
    input  logic expire,
    input  logic ack_rise,
    input  logic pulse_live,
    output logic fire_reset,
    output logic kill
);
    logic first_q;
    logic seen_q;

    always_ff @(posedge clk or negedge pwr_ok) begin
        if (!pwr_ok) begin
            first_q <= 1'b1;
            seen_q  <= 1'b0;
        end else if (rst) begin
            first_q <= 1'b1;
            seen_q  <= 1'b0;
        end else if (tick) begin
            if (expire) begin
                first_q <= 1'b0;
                seen_q  <= ack_rise;
            end else if (ack_rise) begin
                seen_q  <= 1'b1;
            end
        end
    end

    assign fire_reset = first_q | ~seen_q;
    assign kill       = tick & ack_rise & ~expire & ~seen_q & pulse_live;

    // R8
    seen_from_edge_chk: assert property (@(posedge clk) disable iff (rst || !pwr_ok)
        $rose(seen_q) |-> $past(ack_rise));

endmodule

// File: rtl/wkt_pulse_seq.sv
module wkt_pulse_seq
    import wkt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pwr_ok,
    input  logic tick,
    input  logic expire,
    input  logic fire_reset,
    input  logic kill,
    output logic wake_pulse,
    output logic mcu_rst_n,
    output logic cal_pulse,
    output logic pulse_live
);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(SEQ_TICKS - 1);

    seq_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (expire) begin
            st_d.active = 1'b1;
            st_d.killed = 1'b0;
            st_d.kind   = fire_reset ? PK_RESET : PK_WAKE;
            st_d.ph     = '0;
        end else if (tick && st_q.active) begin
            if (kill)
                st_d.killed = 1'b1;
            if (st_q.ph == LAST_PH)
                st_d.active = 1'b0;
            else
                st_d.ph = st_q.ph + PH_W'(1);
        end
    end

    always_ff @(posedge clk or negedge pwr_ok) begin
        if (!pwr_ok)
            st_q <= '0;
        else if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    logic live;
    int   ph_i;
    assign live = pwr_ok & st_q.active;
    assign ph_i = 32'(st_q.ph);

    assign wake_pulse = live & (st_q.kind == PK_WAKE) & ~st_q.killed & (ph_i < WAKE_TICKS);
    assign mcu_rst_n  = ~(live & (st_q.kind == PK_RESET) & (ph_i < RST_TICKS));
    assign cal_pulse  = live & ~st_q.killed & (ph_i >= CAL_START) &
                        (ph_i < CAL_START + CAL_TICKS);
    assign pulse_live = wake_pulse | cal_pulse;

    // R2
    idle_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_ok |-> (!wake_pulse && mcu_rst_n && !cal_pulse));

    // R7
    cal_follows_pulse_chk: assert property (@(posedge clk) disable iff (rst || !pwr_ok)
        $rose(cal_pulse) |-> ($past(wake_pulse) || !$past(mcu_rst_n)));

    // R5
    wake_rst_excl_chk: assert property (@(posedge clk) disable iff (rst || !pwr_ok)
        wake_pulse |-> mcu_rst_n);

endmodule

// File: rtl/wake_wdog_timer.sv
module wake_wdog_timer
    import wkt_pkg::*;
#(
    parameter int BASE_LOG2   = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              pwr_ok,
    input  logic              ack_in,
    input  logic [CODE_W-1:0] delay_code,
    output logic              wake_pulse,
    output logic              mcu_rst_n,
    output logic              cal_pulse
);
    logic ack_rise;
    logic expire;
    logic fire_reset;
    logic kill;
    logic pulse_live;

    wkt_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .ack_in   (ack_in),
        .ack_rise (ack_rise)
    );

    wkt_delay_counter #(.BASE_LOG2(BASE_LOG2)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .pwr_ok (pwr_ok),
        .tick   (tick),
        .code   (delay_code),
        .expire (expire)
    );

    wkt_watchdog u_wdog (
        .clk        (clk),
        .rst        (rst),
        .pwr_ok     (pwr_ok),
        .tick       (tick),
        .expire     (expire),
        .ack_rise   (ack_rise),
        .pulse_live (pulse_live),
        .fire_reset (fire_reset),
        .kill       (kill)
    );

    wkt_pulse_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .pwr_ok     (pwr_ok),
        .tick       (tick),
        .expire     (expire),
        .fire_reset (fire_reset),
        .kill       (kill),
        .wake_pulse (wake_pulse),
        .mcu_rst_n  (mcu_rst_n),
        .cal_pulse  (cal_pulse),
        .pulse_live (pulse_live)
    );

endmodule

// File: tb/test_wake_wdog_timer.sv
module test_wake_wdog_timer;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = CLK_PERIOD / 4;
    localparam int BASE_LOG2  = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic       pwr_ok = 1'b0;
    logic       ack_in = 1'b0;
    logic [2:0] delay_code = 3'd0;
    logic       wake_pulse, mcu_rst_n, cal_pulse;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    wake_wdog_timer #(.BASE_LOG2(BASE_LOG2)) i_wake_wdog_timer (
        .clk(clk), .rst(rst), .tick(tick), .pwr_ok(pwr_ok), .ack_in(ack_in),
        .delay_code(delay_code), .wake_pulse(wake_pulse), .mcu_rst_n(mcu_rst_n),
        .cal_pulse(cal_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic act, input logic exp, input int t);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s t=%0d actual=%b expected=%b", tag, t, act, exp);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk({tag, " wake"}, wake_pulse, 1'b0, -1);
        chk({tag, " rst_n"}, mcu_rst_n, 1'b1, -1);
        chk({tag, " cal"}, cal_pulse, 1'b0, -1);
    endtask

    // multiplier for codes 0..7 (R1)
    function automatic int periods(input int code);
        int b;
        b = 1 << BASE_LOG2;
        if (code == 4) return 10 * b;
        if (code < 4)  return b << code;
        return b << (code - 1);
    endfunction

    initial begin
        // R11: synchronous reset with power present keeps outputs idle
        pwr_ok = 1'b1;
        repeat (5) @(posedge clk);
        #Q;
        chk_idle("R11");
        pwr_ok = 1'b0;
        #Q;
        rst = 1'b0;
        repeat (3) @(posedge clk);
        #Q;
        chk_idle("R2 off");

        for (int code = 0; code < 8; code++) begin
            int n2, end_t;
            n2 = 2 * periods(code);
            end_t = (code % 2 == 0) ? 3 * n2 + 1 : 4 * n2;
            pwr_ok = 1'b0;
            ack_in = 1'b0;
            repeat (3) @(posedge clk);
            #Q;
            chk_idle("R2 off");
            delay_code = 3'(code);
            pwr_ok = 1'b1;
            for (int t = 1; t <= end_t; t++) begin
                int p, ph;
                logic ew, er, ec, cancel, is_rst;
                @(posedge clk);
                #Q;
                p = t / n2;
                ph = t % n2;
                // expiry 1 reset (R4), 2 wake cancelled (R10), 3 wake, 4 reset (R5)
                is_rst = (p == 1) || (p == 4);
                cancel = (p == 2) && (ph >= 3);
                ew = (p >= 1) && !is_rst && (ph < 4) && !cancel;
                er = !((p >= 1) && is_rst && (ph < 2));
                ec = (p >= 1) && (ph >= 1) && (ph < 3) && !cancel;
                // R1 R9: idle before expiry and spacing unchanged by acks
                chk("R1 R5 R6 R9 R10 wake", wake_pulse, ew, t);
                chk("R1 R4 R5 R9 rst_n", mcu_rst_n, er, t);
                chk("R7 R10 cal", cal_pulse, ec, t);
                // R3: later code changes are ignored
                if (t == 3) delay_code = 3'(code) ^ 3'b101;
                // R8: acknowledge in interval 1 -> wake at expiry 2
                if (t == n2 + 6)  ack_in = 1'b1;
                if (t == n2 + 10) ack_in = 1'b0;
                // R10: acknowledge during wake pulse of expiry 2
                if (t == 2 * n2)     ack_in = 1'b1;
                if (t == 2 * n2 + 6) ack_in = 1'b0;
            end
            // R2: drop power mid-pulse, outputs idle without a clock edge
            pwr_ok = 1'b0;
            #1;
            chk_idle("R2 async");
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule